// File: doc/BRIEF.md
# Directly Attached ATA Task-File Window Decoder

This block lets a processor bus reach an ATA/IDE device's task-file registers without a dedicated host controller. It opens two address windows on the bus. The command window holds the eight command-block registers. Their bus addresses are spread out by a shift parameter, so the register index is the window offset shifted right by `SHIFT`. The control window is a short range in which every read returns the device status and every write lands in the device-control register.

A combinational control path decodes each bus access into a small set of strobes. These strobes choose between the 16-bit data port, the 8-bit task-file registers and the control register. A datapath holds a simple storage model of the task file so that the decode can be observed at the ports. In this model the status byte is the last value written to task-file index 7. Write data is taken on the clock edge. Read data follows the address combinationally.

Top module: `ide_win_top`

## Requirements
- R1: After reset, every task-file register, the data port and `devCtrl` read as zero.
- R2: In the command window (`CMD_BASE` up to `CMD_BASE + (16<<SHIFT) - 1`), the index is `(busAddr - CMD_BASE) >> SHIFT`. When bits [2:0] of the index are 1 to 7, the task-file byte with that number is selected. A write stores `busWdata[7:0]`. A read returns that byte in bits [7:0], with all upper bits zero.
- R3: When bits [2:0] of the index are zero, the 16-bit data port is selected. A write stores `busWdata[15:0]`. A read returns that value in bits [15:0], with bits above 15 zero.
- R4: Indices 8 to 15 alias indices 0 to 7, because only bits [2:0] of the index pick the register.
- R5: Address bits below `SHIFT` do not change which register is selected.
- R6: A read anywhere in the control window (`CTL_BASE` up to `CTL_BASE + (2<<SHIFT) - 1`) returns the status byte in bits [7:0], whatever the offset. The status byte is task-file index 7.
- R7: A write anywhere in the control window loads `busWdata[7:0]` into `devCtrl` on the next clock edge, whatever the offset. It leaves the status byte unchanged.
- R8: An access outside both windows has no effect on any register, and a read there returns zero. This includes the first address past each window and the address just below each window.
- R9: The access-size input `busSize` (0 byte, 1 half-word, 2 word) has no effect on the decode or on the data moved.
- R10: Reads have no side effects on stored values or on `devCtrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code, not used by the decode |
| busAddr | input | ADDR_W | Bus byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| devCtrl | output | 8 | Device-control register contents |

## Verification
The assertions assume that `busSel`, `busWr` and `busAddr` are stable around the clock edge. They also assume that the two windows do not overlap, so that a control-window access can never also decode as a command-window access. The bench drives every input on the falling edge and picks its addresses from the default non-overlapping bases. It reads combinational data mid-cycle and checks register contents only after the edge that loads them.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

  // Strobes from the address decode to the register datapath
  typedef struct packed {
    logic       dataWr;
    logic       dataRd;
    logic       tfWr;
    logic       tfRd;
    logic [2:0] tfIdx;
    logic       ctlWr;
    logic       ctlRd;
  } ide_strobe_t;

endpackage

// File: rtl/ide_win_ctrl.sv
module ide_win_ctrl
  import ide_win_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       SHIFT    = 1,
  parameter logic [ADDR_W-1:0] CMD_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h080C
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ide_strobe_t       strobe
);

  localparam logic [ADDR_W-1:0] CMD_REGS = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] CTL_REGS = ADDR_W'(2);

  logic [ADDR_W-1:0] cmdIdx;
  logic [ADDR_W-1:0] ctlIdx;
  logic inCmd;
  logic inCtl;
  logic cmdAcc;
  logic ctlAcc;
  logic isData;

  // The window test is done on the shifted offset, so every address bit counts
  assign cmdIdx = (busAddr - CMD_BASE) >> SHIFT;
  assign ctlIdx = (busAddr - CTL_BASE) >> SHIFT;
  assign inCmd  = (busAddr >= CMD_BASE) && (cmdIdx < CMD_REGS);
  assign inCtl  = (busAddr >= CTL_BASE) && (ctlIdx < CTL_REGS);

  assign cmdAcc = busSel && inCmd;
  assign ctlAcc = busSel && inCtl && !inCmd;
  assign isData = (cmdIdx[2:0] == 3'd0);

  always_comb begin
    strobe        = '0;
    strobe.tfIdx  = cmdIdx[2:0];
    strobe.dataWr = cmdAcc && isData && busWr;
    strobe.dataRd = cmdAcc && isData && !busWr;
    strobe.tfWr   = cmdAcc && !isData && busWr;
    strobe.tfRd   = cmdAcc && !isData && !busWr;
    strobe.ctlWr  = ctlAcc && busWr;
    strobe.ctlRd  = ctlAcc && !busWr;
  end

endmodule

// File: rtl/ide_win_datapath.sv
module ide_win_datapath
  import ide_win_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ide_strobe_t       strobe,
  input  logic [15:0]       wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        devCtrl
);

  localparam int unsigned TF_REGS = 7;

  logic [15:0] dataReg;
  logic [7:0]  tfReg [1:TF_REGS];
  logic [7:0]  ctlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataReg <= '0;
    else if (strobe.dataWr) dataReg <= wrData;
  end

  for (genvar g = 1; g <= TF_REGS; g++) begin : g_tf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    tfReg[g] <= '0;
      else if (strobe.tfWr && strobe.tfIdx == 3'(g)) tfReg[g] <= wrData[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctlReg <= '0;
    else if (strobe.ctlWr) ctlReg <= wrData[7:0];
  end

  assign devCtrl = ctlReg;

  always_comb begin
    rdData = '0;
    if (strobe.dataRd) begin
      rdData[15:0] = dataReg;
    end else if (strobe.tfRd) begin
      for (int k = 1; k <= TF_REGS; k++)
        if (strobe.tfIdx == 3'(k)) rdData[7:0] = tfReg[k];
    end else if (strobe.ctlRd) begin
      rdData[7:0] = tfReg[TF_REGS];
    end
  end

endmodule

// File: rtl/ide_win_top.sv
module ide_win_top
  import ide_win_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       SHIFT    = 1,
  parameter logic [ADDR_W-1:0] CMD_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h080C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [7:0]        devCtrl
);

  ide_strobe_t strobe;

  // Size code and upper data lanes play no part in the decode
  logic unusedBits;
  assign unusedBits = ^{busSize, busWdata[DATA_W-1:16]};

  ide_win_ctrl #(
    .ADDR_W(ADDR_W), .SHIFT(SHIFT), .CMD_BASE(CMD_BASE), .CTL_BASE(CTL_BASE)
  ) i_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  ide_win_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWdata[15:0]),
    .rdData (busRdata),
    .devCtrl(devCtrl)
  );

endmodule

// File: rtl/ide_win_checker.sv
module ide_win_checker #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       SHIFT    = 1,
  parameter logic [ADDR_W-1:0] CMD_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h080C
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic [7:0]        devCtrl
);

  logic [ADDR_W-1:0] offCmd;
  logic [ADDR_W-1:0] offCtl;
  logic hitCmd;
  logic hitCtl;

  assign offCmd = (busAddr - CMD_BASE) >> SHIFT;
  assign offCtl = (busAddr - CTL_BASE) >> SHIFT;
  assign hitCmd = (busAddr >= CMD_BASE) && (offCmd < ADDR_W'(16));
  assign hitCtl = (busAddr >= CTL_BASE) && (offCtl < ADDR_W'(2));

  // R8: reads outside both windows return zero
  a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !hitCmd && !hitCtl) |-> (busRdata == '0));

  // R3: data-port reads drive nothing above bit 15
  a_r3_data_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && hitCmd && offCmd[2:0] == 3'd0) |-> (busRdata[DATA_W-1:16] == '0));

  // R2: task-file and status reads drive nothing above bit 7
  a_r2_tf_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (hitCtl || (hitCmd && offCmd[2:0] != 3'd0))) |->
      (busRdata[DATA_W-1:8] == '0));

  // R7: devCtrl only moves after a control-window write
  a_r7_ctl_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devCtrl) |-> $past(busSel && busWr && hitCtl && !hitCmd));

  // R10: a read leaves devCtrl as it was
  a_r10_read_keeps_ctl: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr) |=> $stable(devCtrl));

  // R1: devCtrl held at zero in reset
  always @(posedge clk)
    if (!rstN) a_r1_reset_ctl: assert (devCtrl == 8'h00);

endmodule

bind ide_win_top ide_win_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT(SHIFT),
  .CMD_BASE(CMD_BASE), .CTL_BASE(CTL_BASE)
) i_ide_win_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .devCtrl (devCtrl)
);

// File: tb/test_ide_win_top.sv
module test_ide_win_top;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam logic [15:0] CMD = 16'h1000;
  localparam logic [15:0] CTL = 16'h080C;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [1:0]        busSize = 2'd2;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [7:0]        devCtrl;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ide_win_top i_ide_win_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .devCtrl(devCtrl)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busSize = sz;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busSize = sz;
    #2 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  function automatic logic [15:0] regAddr(input int idx);
    return CMD + 16'(idx << 1);
  endfunction

  task automatic t_reset();
    logic [31:0] r;
    check("R1 devCtrl", {24'b0, devCtrl}, 32'h0);
    busRead(regAddr(0), r); check("R1 data port", r, 32'h0);
    busRead(regAddr(3), r); check("R1 tf3", r, 32'h0);
    busRead(CTL, r);        check("R1 status", r, 32'h0);
  endtask

  task automatic t_taskfile();
    logic [31:0] r;
    for (int i = 1; i < 8; i++) busWrite(regAddr(i), 32'hABCD_5600 | 32'(8'h11 * i));
    for (int i = 1; i < 8; i++) begin
      busRead(regAddr(i), r);
      check($sformatf("R2 tf%0d", i), r, 32'(8'(8'h11 * i)));
    end
  endtask

  task automatic t_dataport();
    logic [31:0] r;
    busWrite(regAddr(0), 32'hFFFF_BEEF);
    busRead(regAddr(0), r); check("R3 data port", r, 32'h0000_BEEF);
    busRead(regAddr(8), r); check("R4 idx8 alias data", r, 32'h0000_BEEF);
    busWrite(regAddr(9), 32'h0000_00C3);
    busRead(regAddr(1), r); check("R4 idx9 alias tf1", r, 32'h0000_00C3);
  endtask

  task automatic t_subshift();
    logic [31:0] r;
    busRead(CMD + 16'd7, r);  check("R5 odd addr tf3", r, 32'h0000_0033);
    busWrite(CMD + 16'd5, 32'h0000_005A);
    busRead(regAddr(2), r);   check("R5 odd write tf2", r, 32'h0000_005A);
  endtask

  task automatic t_control();
    logic [31:0] r;
    busWrite(regAddr(7), 32'h0000_0050);
    for (int o = 0; o < 4; o++) begin
      busRead(CTL + 16'(o), r);
      check($sformatf("R6 status off%0d", o), r, 32'h0000_0050);
    end
    busWrite(CTL + 16'd2, 32'h1234_5606);
    check("R7 devCtrl", {24'b0, devCtrl}, 32'h06);
    busRead(regAddr(7), r); check("R7 status kept", r, 32'h0000_0050);
    busWrite(CTL + 16'd1, 32'h0000_0002);
    check("R7 devCtrl off1", {24'b0, devCtrl}, 32'h02);
  endtask

  task automatic t_outside();
    logic [31:0] r;
    busWrite(CMD + 16'h0020, 32'h0000_00EE);
    busWrite(CMD - 16'd2, 32'h0000_00EE);
    busWrite(CTL + 16'd4, 32'h0000_00EE);
    busWrite(CTL - 16'd1, 32'h0000_00EE);
    check("R8 devCtrl untouched", {24'b0, devCtrl}, 32'h02);
    busRead(CMD + 16'h0020, r); check("R8 past cmd", r, 32'h0);
    busRead(CTL + 16'd4, r);    check("R8 past ctl", r, 32'h0);
    busRead(CTL - 16'd1, r);    check("R8 below ctl", r, 32'h0);
    busRead(regAddr(0), r);     check("R8 data kept", r, 32'h0000_BEEF);
    busRead(regAddr(4), r);     check("R8 tf4 kept", r, 32'h0000_0044);
  endtask

  task automatic t_size();
    logic [31:0] r;
    busWrite(regAddr(5), 32'h0000_0071, 2'd0);
    busRead(regAddr(5), r, 2'd1); check("R9 byte write tf5", r, 32'h0000_0071);
    busWrite(regAddr(0), 32'h0000_1357, 2'd1);
    busRead(regAddr(0), r, 2'd0); check("R9 half data port", r, 32'h0000_1357);
  endtask

  task automatic t_readside();
    logic [31:0] r;
    busRead(regAddr(0), r);
    busRead(regAddr(0), r); check("R10 data repeat", r, 32'h0000_1357);
    busRead(CTL, r);
    busRead(CTL + 16'd3, r);
    check("R10 devCtrl after reads", {24'b0, devCtrl}, 32'h02);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_taskfile();
    t_dataport();
    t_subshift();
    t_control();
    t_outside();
    t_size();
    t_readside();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule